// File: doc/BRIEF.md
# Feedback Divider Serial Control Register

This block keeps the feedback-divider setting of a clock synthesizer. A three-wire serial port (serial clock, serial data, load line) shifts bits into a 6-bit shift register. Dropping the load line copies that register into a holding register. A mode input selects between two settings. One is a fixed nominal setting: feedback 50, pre-divide 2, output divide 2. The other is margining, which uses the held code as the feedback divider. The pre-divide and output-divide values stay fixed in both modes.

The serial clock, serial data and load line come from outside and have no timing relation to the system clock. Each passes through a two-flop synchronizer. Edges of the serial clock and of the load line are found in the system clock domain. Downstream divider logic reads the feedback, pre-divide and output-divide values.

The block also gives a range flag for held codes the loop cannot lock to. It gives a signed margin step, where one step is a 2% change in output frequency.

All pins are plain control or status pins. There is no valid/ready stream anywhere, so no back-pressure rules apply.

Top module: `fbdiv_serial_ctrl`

## Requirements
- R1: After reset the shift register and the held code both contain 50 (binary 110010). `fb_div` reads 50 in either mode, and `margin_step` reads 0.
- R2: While `ser_ld` is high, each rising edge of `ser_clk` shifts `ser_dat` into bit 0, and the older bits move up one place. The first bit sent therefore ends in bit 5 (the MSB) once six bits have gone in.
- R3: A high-to-low transition of `ser_ld` copies the shift register into the held code. The held code does not change at any other time, including while shifting is in progress.
- R4: While `ser_ld` is low, edges on `ser_clk` and values on `ser_dat` change neither the shift register nor the held code.
- R5: With `margin_en` low, `fb_div` is 50, `pre_div` is 2 and `out_div` is 2, whatever code is held.
- R6: With `margin_en` high, `fb_div` equals the held 6-bit code. `pre_div` and `out_div` stay at 2.
- R7: `range_err` is high only when `margin_en` is high and the held code is below 45 or above 55. Codes 45 and 55 are in range.
- R8: Loading and committing work while `margin_en` is low. Setting `margin_en` high later shows the new code. Returning `margin_en` to low restores the nominal setting and leaves the held code unchanged.
- R9: `margin_step` is the held code minus 50, as a 7-bit two's-complement value. It spans -50 (code 0) to +13 (code 63).
- R10: If more than six bits are shifted before the load line drops, only the last six bits sent are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data bit, MSB first, asynchronous |
| ser_ld | input | 1 | Shift enable while high; commit on falling edge |
| margin_en | input | 1 | 0 selects the nominal setting, 1 selects the held code |
| fb_div | output | 6 | Effective feedback divider value |
| pre_div | output | 4 | Pre-divider value |
| out_div | output | 4 | Output divider value |
| range_err | output | 1 | Held code is outside 45..55 while margining |
| margin_step | output | 7 | Signed held code minus 50 |

## Verification
The assertions check these rules on every cycle:
- The held code changes only in the cycle after a detected fall of the load line.
- The shift register changes only after an enabled serial-clock rise.
- The nominal outputs appear whenever margining is off.
- The range flag agrees with the effective code.
- The margin step tracks the effective code.

Some behaviour only the directed scenarios can show:
- bit order (MSB first);
- keeping the last six bits of an overlong frame;
- that activity on a low load line leaves the shift contents intact;
- that the stored code survives a trip through nominal mode.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int CODE_W_D   = 6;
  localparam int DEF_CODE_D = 50;
  localparam int MIN_CODE_D = 45;
  localparam int MAX_CODE_D = 55;
  localparam int DIV_W_D    = 4;
  localparam int PRE_DIV_D  = 2;
  localparam int OUT_DIV_D  = 2;
  localparam int SYNC_D     = 2;
endpackage

// File: rtl/fbdiv_sync.sv
module fbdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/fbdiv_edge.sv
module fbdiv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/fbdiv_shift.sv
module fbdiv_shift #(
  parameter int CODE_W   = 6,
  parameter int DEF_CODE = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [CODE_W-1:0] q
);
  localparam logic [CODE_W-1:0] RST_VAL = CODE_W'(DEF_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= RST_VAL;
    else if (shift_en) q <= {q[CODE_W-2:0], bit_i};
  end
endmodule

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg #(
  parameter int CODE_W   = 6,
  parameter int DEF_CODE = 50,
  parameter int MIN_CODE = 45,
  parameter int MAX_CODE = 55,
  parameter int DIV_W    = 4,
  parameter int PRE_DIV  = 2,
  parameter int OUT_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CODE_W-1:0] shift_q,
  input  logic              margin_en,
  output logic [CODE_W-1:0] hold_q,
  output logic [CODE_W-1:0] fb_div,
  output logic [DIV_W-1:0]  pre_div,
  output logic [DIV_W-1:0]  out_div,
  output logic              range_err,
  output logic [CODE_W:0]   margin_step
);
  localparam int STEP_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] DEF_L = CODE_W'(DEF_CODE);
  localparam logic [CODE_W-1:0] MIN_L = CODE_W'(MIN_CODE);
  localparam logic [CODE_W-1:0] MAX_L = CODE_W'(MAX_CODE);
  localparam logic [STEP_W-1:0] DEF_S = STEP_W'(DEF_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= DEF_L;
    else if (commit) hold_q <= shift_q;
  end

  logic out_of_band;
  assign out_of_band = (hold_q < MIN_L) || (hold_q > MAX_L);

  always_comb begin
    fb_div      = margin_en ? hold_q : DEF_L;
    pre_div     = DIV_W'(PRE_DIV);
    out_div     = DIV_W'(OUT_DIV);
    range_err   = margin_en & out_of_band;
    margin_step = {1'b0, hold_q} - DEF_S;
  end
endmodule

// File: rtl/fbdiv_serial_ctrl.sv
module fbdiv_serial_ctrl
  import fbdiv_pkg::*;
#(
  parameter int CODE_W      = CODE_W_D,
  parameter int DEF_CODE    = DEF_CODE_D,
  parameter int MIN_CODE    = MIN_CODE_D,
  parameter int MAX_CODE    = MAX_CODE_D,
  parameter int DIV_W       = DIV_W_D,
  parameter int PRE_DIV     = PRE_DIV_D,
  parameter int OUT_DIV     = OUT_DIV_D,
  parameter int SYNC_STAGES = SYNC_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_ld,
  input  logic              margin_en,
  output logic [CODE_W-1:0] fb_div,
  output logic [DIV_W-1:0]  pre_div,
  output logic [DIV_W-1:0]  out_div,
  output logic              range_err,
  output logic [CODE_W:0]   margin_step
);
  localparam int N_IN = 3;
  localparam int I_CLK = 0;
  localparam int I_DAT = 1;
  localparam int I_LD  = 2;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] sync_lvl;
  assign raw_in = {ser_ld, ser_dat, ser_clk};

  // Equal synchronizer depth on every serial line keeps data aligned to its clock.
  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    fbdiv_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(raw_in[g]), .level_o(sync_lvl[g])
    );
  end

  logic sclk_rise, sclk_fall, ld_rise, ld_fall;

  fbdiv_edge sclk_edge_i (
    .clk(clk), .rst_n(rst_n), .level_i(sync_lvl[I_CLK]),
    .rise_o(sclk_rise), .fall_o(sclk_fall)
  );
  fbdiv_edge ld_edge_i (
    .clk(clk), .rst_n(rst_n), .level_i(sync_lvl[I_LD]),
    .rise_o(ld_rise), .fall_o(ld_fall)
  );

  logic shift_en, commit;
  logic unused_edges;
  assign shift_en     = sync_lvl[I_LD] & sclk_rise;
  assign commit       = ld_fall;
  assign unused_edges = sclk_fall ^ ld_rise;

  logic [CODE_W-1:0] shift_q;
  logic [CODE_W-1:0] hold_q;

  fbdiv_shift #(.CODE_W(CODE_W), .DEF_CODE(DEF_CODE)) shift_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .bit_i(sync_lvl[I_DAT]), .q(shift_q)
  );

  fbdiv_cfg #(
    .CODE_W(CODE_W), .DEF_CODE(DEF_CODE), .MIN_CODE(MIN_CODE),
    .MAX_CODE(MAX_CODE), .DIV_W(DIV_W), .PRE_DIV(PRE_DIV), .OUT_DIV(OUT_DIV)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .shift_q(shift_q),
    .margin_en(margin_en), .hold_q(hold_q), .fb_div(fb_div),
    .pre_div(pre_div), .out_div(out_div), .range_err(range_err),
    .margin_step(margin_step)
  );
endmodule

// File: rtl/fbdiv_serial_ctrl_chk.sv
module fbdiv_serial_ctrl_chk #(
  parameter int CODE_W   = 6,
  parameter int DEF_CODE = 50,
  parameter int MIN_CODE = 45,
  parameter int MAX_CODE = 55,
  parameter int DIV_W    = 4,
  parameter int PRE_DIV  = 2,
  parameter int OUT_DIV  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              margin_en,
  input logic [CODE_W-1:0] fb_div,
  input logic [DIV_W-1:0]  pre_div,
  input logic [DIV_W-1:0]  out_div,
  input logic              range_err,
  input logic [CODE_W:0]   margin_step,
  input logic [CODE_W-1:0] shift_q,
  input logic [CODE_W-1:0] hold_q,
  input logic              shift_en,
  input logic              commit
);
  localparam logic [CODE_W-1:0] DEF_L = CODE_W'(DEF_CODE);

  // R3: the held code moves only right after a commit strobe
  assert_hold_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_q) |-> $past(commit));

  // R2 / R4: the shift register moves only after an enabled serial-clock rise
  assert_shift_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shift_q) |-> $past(shift_en));

  // R5: nominal setting whenever margining is off
  assert_nominal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !margin_en |-> (fb_div == DEF_L && pre_div == DIV_W'(PRE_DIV)
                    && out_div == DIV_W'(OUT_DIV) && !range_err));

  // R6: margining output follows the held code
  assert_margin_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    margin_en |-> fb_div == hold_q);

  // R7: flag agrees with the effective code
  assert_range_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    margin_en |-> range_err == (int'(fb_div) < MIN_CODE || int'(fb_div) > MAX_CODE));

  // R9: step equals effective code minus nominal while margining
  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    margin_en |-> int'($signed(margin_step)) == int'(fb_div) - DEF_CODE);
endmodule

bind fbdiv_serial_ctrl fbdiv_serial_ctrl_chk #(
  .CODE_W(CODE_W), .DEF_CODE(DEF_CODE), .MIN_CODE(MIN_CODE),
  .MAX_CODE(MAX_CODE), .DIV_W(DIV_W), .PRE_DIV(PRE_DIV), .OUT_DIV(OUT_DIV)
) chk_i (
  .clk(clk), .rst_n(rst_n), .margin_en(margin_en), .fb_div(fb_div),
  .pre_div(pre_div), .out_div(out_div), .range_err(range_err),
  .margin_step(margin_step), .shift_q(shift_q), .hold_q(hold_q),
  .shift_en(shift_en), .commit(commit)
);

// File: tb/fbdiv_serial_ctrl_tb_top.sv
module fbdiv_serial_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, margin_en = 1'b0;
  logic [5:0] fb_div;
  logic [3:0] pre_div, out_div;
  logic range_err;
  logic [6:0] margin_step;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fbdiv_serial_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .margin_en(margin_en), .fb_div(fb_div),
    .pre_div(pre_div), .out_div(out_div), .range_err(range_err),
    .margin_step(margin_step)
  );

  task automatic check(string tag, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      idle(3);
      ser_clk = 1'b1;
      idle(3);
      ser_clk = 1'b0;
      idle(2);
    end
  endtask

  task automatic load_code(logic [7:0] v, int n);
    ser_ld = 1'b1;
    idle(3);
    send_bits(v, n);
    ser_ld = 1'b0;
    idle(6);
  endtask

  task automatic expect_margin(string tag, int code, bit err);
    margin_en = 1'b1;
    idle(1);
    check({tag, " fb_div"}, int'(fb_div), code);
    check({tag, " range_err"}, int'(range_err), int'(err));
    check({tag, " step"}, int'($signed(margin_step)), code - 50);
  endtask

  task automatic t_reset_R1;
    check("R1 fb_div nominal", int'(fb_div), 50);
    check("R1 step zero", int'($signed(margin_step)), 0);
    check("R5 pre_div", int'(pre_div), 2);
    check("R5 out_div", int'(out_div), 2);
    margin_en = 1'b1;
    idle(1);
    check("R1 held code after reset", int'(fb_div), 50);
    margin_en = 1'b0;
    idle(1);
  endtask

  task automatic t_basic_R2_R6;
    margin_en = 1'b1;
    load_code(8'd52, 6);
    expect_margin("R2 R6 code 52", 52, 1'b0);
    check("R6 pre_div fixed", int'(pre_div), 2);
    load_code(8'b000001, 6);
    expect_margin("R2 MSB first code 1", 1, 1'b1);
  endtask

  task automatic t_bounds_R7_R9;
    load_code(8'd45, 6); expect_margin("R7 low edge 45", 45, 1'b0);
    load_code(8'd55, 6); expect_margin("R7 high edge 55", 55, 1'b0);
    load_code(8'd44, 6); expect_margin("R7 below 44", 44, 1'b1);
    load_code(8'd56, 6); expect_margin("R7 above 56", 56, 1'b1);
    load_code(8'd0, 6);  expect_margin("R9 code 0", 0, 1'b1);
    load_code(8'd63, 6); expect_margin("R9 code 63", 63, 1'b1);
  endtask

  task automatic t_default_mode_R5_R8;
    load_code(8'd44, 6);
    margin_en = 1'b0;
    idle(1);
    check("R5 fb_div nominal with 44 held", int'(fb_div), 50);
    check("R7 no flag in default mode", int'(range_err), 0);
    load_code(8'd53, 6);
    check("R8 load in default keeps nominal", int'(fb_div), 50);
    expect_margin("R8 code loaded in default", 53, 1'b0);
    margin_en = 1'b0;
    idle(2);
    check("R8 back to nominal", int'(fb_div), 50);
    expect_margin("R8 code kept", 53, 1'b0);
  endtask

  task automatic t_ignored_R4;
    ser_ld = 1'b0;
    idle(2);
    send_bits(8'b101010, 6);
    idle(6);
    check("R4 held unchanged by idle clocks", int'(fb_div), 53);
    ser_ld = 1'b1;
    idle(8);
    ser_ld = 1'b0;
    idle(6);
    check("R4 shift contents unchanged", int'(fb_div), 53);
  endtask

  task automatic t_pending_R3;
    ser_ld = 1'b1;
    idle(3);
    send_bits(8'd46, 6);
    idle(6);
    check("R3 no commit before fall", int'(fb_div), 53);
    ser_ld = 1'b0;
    idle(6);
    expect_margin("R3 commit on fall", 46, 1'b0);
  endtask

  task automatic t_overlong_R10;
    load_code(8'b10110111, 8);
    expect_margin("R10 last six bits", 55, 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset_R1();
    t_basic_R2_R6();
    t_bounds_R7_R9();
    t_default_mode_R5_R8();
    t_ignored_R4();
    t_pending_R3();
    t_overlong_R10();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule